// File: doc/BRIEF.md
# Transmit Descriptor Close Unit

This block finishes the life of one transmit descriptor once the frame it describes has left the DMA engine. On a close request it captures the descriptor's base address, the size mode (4 or 8 words), the control word latched when the descriptor was fetched, the frame status and a 64-bit timestamp. It then writes the results back to descriptor memory over a valid/ready word-write port, one word per accepted handshake.

Word 0 is rebuilt so that the ownership flag (bit 31) reads clear, the control field (bits 30 to 18) matches what software originally programmed, and bits 17 to 0 carry the new frame status. When the descriptor is 8 words long and its snapshot bit (word 0, bit 25) is set, the timestamp goes into words 6 and 7 first. Word 0 is written last, so software never finds the ownership flag cleared while the timestamp words are still stale. The block also reports where the next descriptor starts: 16 or 32 bytes past the current one.

Top module: `txdesc_wb`

## Requirements
- R1: After reset, `wr_valid_o` and `done_o` are low.
- R2: The word-0 write goes to the base address and carries bit 31 = 0, bits 30:18 equal to bits 30:18 of the captured control word, and bits 17:0 equal to the captured frame status.
- R3: In 8-word mode (`wide_desc_i` = 1) with control bit 25 set, three writes occur in this order: base+24 with timestamp bits 31:0, base+28 with timestamp bits 63:32, then word 0.
- R4: In 8-word mode with control bit 25 clear, exactly one write occurs: word 0.
- R5: In 4-word mode (`wide_desc_i` = 0), exactly one write occurs (word 0) whatever bit 25 holds, and no address from base+16 to base+31 is ever written.
- R6: Once `done_o` is seen, `next_desc_o` equals the captured base plus 32 in 8-word mode, or plus 16 in 4-word mode.
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, the write stays pending with unchanged address and data. Each word is accepted exactly once.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last write is accepted.
- R9: A close request that arrives while a write-back is in progress is ignored. It neither changes the ongoing writes nor starts a new write-back.
- R10: Inputs are captured on the accepted close request. Changes to them afterwards do not affect the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| close_i | input | 1 | Request to close the current descriptor |
| desc_base_i | input | AW | Byte address of the current descriptor |
| wide_desc_i | input | 1 | 1: 8-word descriptors, 0: 4-word descriptors |
| ctrl_word_i | input | 32 | Word 0 as captured at fetch time |
| frame_status_i | input | 18 | Frame status to place in word 0 bits 17:0 |
| tstamp_i | input | 64 | Timestamp captured for the frame |
| wr_valid_o | output | 1 | Word write request |
| wr_ready_i | input | 1 | Memory accepts the write this cycle |
| wr_addr_o | output | AW | Byte address of the word being written |
| wr_data_o | output | 32 | Data of the word being written |
| done_o | output | 1 | One-cycle pulse when the write-back has finished |
| next_desc_o | output | AW | Byte address of the following descriptor |

## Verification
Random frames mix both size modes, both states of the snapshot bit, random control, status and timestamp values, and random ready stalls. Comparing write count, order and contents separates the three-write sequence from the single-write ones, and shows that 4-word mode keeps the extended words untouched even when a snapshot was requested. Directed frames add four cases: ready held high, which pins down the done latency with no stalls in between; inputs scrambled after capture; a spurious close during a stalled write-back, which shows busy requests are dropped; and the address arithmetic across each size mode.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STAT_W   = 18;
  localparam int unsigned TS_W     = 2 * WORD_W;
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned SNAP_BIT = 25;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TS_LO,
    ST_TS_HI,
    ST_CTRL
  } wb_state_e;

  // Ownership cleared, control field restored, status refreshed
  function automatic logic [WORD_W-1:0] close_word0(input logic [WORD_W-1:0] ctrl,
                                                     input logic [STAT_W-1:0] stat);
    return {1'b0, ctrl[OWN_BIT-1:STAT_W], stat};
  endfunction
endpackage

// File: rtl/txdesc_seq.sv
module txdesc_seq
  import txdesc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      wide_i,
  input  logic      snap_i,
  input  logic      acc_i,
  output wb_state_e state_o,
  output logic [2:0] word_idx_o,
  output logic      done_o
);
  wb_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = (wide_i && snap_i) ? ST_TS_LO : ST_CTRL;
      ST_TS_LO: if (acc_i) state_d = ST_TS_HI;
      ST_TS_HI: if (acc_i) state_d = ST_CTRL;
      ST_CTRL:  if (acc_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_CTRL) && acc_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_TS_LO: word_idx_o = 3'd6;
      ST_TS_HI: word_idx_o = 3'd7;
      default:  word_idx_o = 3'd0;
    endcase
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CTRL && acc_i) |=> done_o && state_q == ST_IDLE);
  a_r3_ts_then_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TS_HI && acc_i) |=> state_q == ST_CTRL);
endmodule

// File: rtl/txdesc_addr.sv
module txdesc_addr #(
  parameter int unsigned AW          = 32,
  parameter int unsigned WORDS_SMALL = 4,
  parameter int unsigned WORDS_BIG   = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic          wide_i,
  input  logic [2:0]    idx_i,
  output logic [AW-1:0] word_addr_o,
  output logic [AW-1:0] next_addr_o
);
  localparam int unsigned SMALL_BYTES = WORDS_SMALL * 4;
  localparam int unsigned BIG_BYTES   = WORDS_BIG * 4;

  assign word_addr_o = base_i + (AW'(idx_i) << 2);
  assign next_addr_o = base_i + (wide_i ? AW'(BIG_BYTES) : AW'(SMALL_BYTES));
endmodule

// File: rtl/txdesc_wb.sv
module txdesc_wb
  import txdesc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic [AW-1:0]     desc_base_i,
  input  logic              wide_desc_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic [STAT_W-1:0] frame_status_i,
  input  logic [TS_W-1:0]   tstamp_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic [AW-1:0]     next_desc_o
);
  localparam int unsigned SMALL_SPAN = 16;

  wb_state_e         state;
  logic [2:0]        word_idx;
  logic              start, acc;
  logic [AW-1:0]     base_q;
  logic              wide_q;
  logic [WORD_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [TS_W-1:0]   ts_q;

  assign start = close_i && (state == ST_IDLE);
  assign acc   = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      wide_q <= 1'b0;
      ctrl_q <= '0;
      stat_q <= '0;
      ts_q   <= '0;
    end else if (start) begin
      base_q <= desc_base_i;
      wide_q <= wide_desc_i;
      ctrl_q <= ctrl_word_i;
      stat_q <= frame_status_i;
      ts_q   <= tstamp_i;
    end
  end

  txdesc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wide_i     (wide_desc_i),
    .snap_i     (ctrl_word_i[SNAP_BIT]),
    .acc_i      (acc),
    .state_o    (state),
    .word_idx_o (word_idx),
    .done_o     (done_o)
  );

  txdesc_addr #(.AW(AW)) u_addr (
    .base_i      (base_q),
    .wide_i      (wide_q),
    .idx_i       (word_idx),
    .word_addr_o (wr_addr_o),
    .next_addr_o (next_desc_o)
  );

  assign wr_valid_o = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_TS_LO: wr_data_o = ts_q[WORD_W-1:0];
      ST_TS_HI: wr_data_o = ts_q[TS_W-1:WORD_W];
      default:  wr_data_o = close_word0(ctrl_q, stat_q);
    endcase
  end

  a_r7_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  a_r5_narrow_no_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wide_q) |-> (wr_addr_o - base_q) < AW'(SMALL_SPAN));
  a_r9_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && wr_valid_o) |=> $stable(base_q) && $stable(ts_q) && $stable(ctrl_q));
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);
endmodule

// File: tb/sim_txdesc_wb.sv
module sim_txdesc_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        close = 1'b0;
  logic [31:0] base = '0;
  logic        wide = 1'b0;
  logic [31:0] ctrl = '0;
  logic [17:0] stat = '0;
  logic [63:0] ts = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data, next_desc;
  logic        done;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  txdesc_wb u0 (
    .clk_i(clk), .rst_ni(rst_n), .close_i(close), .desc_base_i(base),
    .wide_desc_i(wide), .ctrl_word_i(ctrl), .frame_status_i(stat), .tstamp_i(ts),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .next_desc_o(next_desc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word0(input logic [31:0] c, input logic [17:0] s);
    return {1'b0, c[30:18], s};
  endfunction

  task automatic run_frame(input logic [31:0] b, input logic wm, input logic [31:0] c,
                           input logic [17:0] s, input logic [63:0] t,
                           input int ready_pct, input bit spurious);
    logic [31:0] ea[3], ed[3];
    int en, got, cyc, last_acc;
    bit stalled, seen;
    logic [31:0] pa, pd;
    string tag;
    if (wm && c[25]) begin
      ea[0] = b + 24; ed[0] = t[31:0];
      ea[1] = b + 28; ed[1] = t[63:32];
      ea[2] = b;      ed[2] = exp_word0(c, s);
      en = 3; tag = "R3";
    end else begin
      ea[0] = b; ed[0] = exp_word0(c, s);
      en = 1; tag = wm ? "R4" : "R5";
    end
    @(negedge clk);
    base = b; wide = wm; ctrl = c; stat = s; ts = t; close = 1'b1;
    @(negedge clk);
    close = 1'b0;
    // R10: scramble inputs after capture
    base = $urandom; wide = ~wm; ctrl = $urandom; stat = 18'($urandom); ts = {$urandom, $urandom};
    got = 0; cyc = 0; last_acc = -1; stalled = 0; seen = 0;
    while (cyc < 400) begin
      if (done) begin
        seen = 1;
        chk(cyc - last_acc == 1, "R8 done latency", 64'(cyc - last_acc), 64'd1);
        break;
      end
      close = (spurious && cyc == 1);
      if (close) base = b + 32'h100;
      wr_ready = (spurious && cyc == 0) ? 1'b0 : (($urandom % 100) < ready_pct);
      #1;
      if (stalled)
        chk(wr_valid && wr_addr == pa && wr_data == pd, "R7 held", {wr_addr, wr_data}, {pa, pd});
      if (wr_valid && wr_ready) begin
        if (got < en) begin
          chk(wr_addr == ea[got], {tag, " addr R10"}, 64'(wr_addr), 64'(ea[got]));
          chk(wr_data == ed[got], (got == en - 1) ? {tag, " R2 word0"} : {tag, " ts word"},
              64'(wr_data), 64'(ed[got]));
          if (!wm) chk(wr_addr - b < 16, "R5 ext range", 64'(wr_addr), 64'(b));
        end else begin
          chk(1'b0, {tag, " R7 extra write"}, 64'(wr_addr), 64'(0));
        end
        got++; last_acc = cyc; stalled = 0;
      end else if (wr_valid) begin
        stalled = 1; pa = wr_addr; pd = wr_data;
      end else begin
        stalled = 0;
      end
      @(negedge clk);
      cyc++;
    end
    close = 1'b0;
    wr_ready = 1'b0;
    chk(seen, "R8 done seen", 64'(seen), 64'd1);
    chk(got == en, {tag, " R7 write count"}, 64'(got), 64'(en));
    chk(next_desc == b + (wm ? 32 : 16), "R6 next addr", 64'(next_desc), 64'(b + (wm ? 32 : 16)));
    @(negedge clk);
    chk(!done, "R8 pulse width", 64'(done), 64'd0);
    chk(!wr_valid, spurious ? "R9 no restart" : "R9 idle after", 64'(wr_valid), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    #1;
    chk(!wr_valid && !done, "R1 reset outputs", {wr_valid, done}, 0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !done, "R1 after release", {wr_valid, done}, 0);
    // Directed corners
    run_frame(32'h0000_1000, 1'b1, 32'hFFFF_FFFF, 18'h3FFFF, 64'h1122_3344_5566_7788, 100, 0); // R3
    run_frame(32'h0000_2000, 1'b1, 32'hFDFF_FFFF, 18'h00001, 64'hDEAD_BEEF_0BAD_F00D, 100, 0); // R4
    run_frame(32'h0000_3000, 1'b0, 32'h8200_0000, 18'h2AAAA, 64'hCAFE_0000_0000_CAFE, 100, 0); // R5
    run_frame(32'hFFFF_FFE0, 1'b1, 32'h0200_0000, 18'h15555, 64'h0123_4567_89AB_CDEF, 30, 0);  // R6 wrap
    run_frame(32'h0000_4000, 1'b1, 32'h8204_0000, 18'h0F0F0, 64'hAAAA_5555_AAAA_5555, 50, 1);  // R9
    run_frame(32'h0000_5000, 1'b0, 32'h0000_0000, 18'h00000, 64'h0, 40, 1);                    // R9
    for (int i = 0; i < 60; i++) begin
      logic [31:0] rb, rc;
      rb = {$urandom} & 32'hFFFF_FFF0;
      rc = $urandom;
      run_frame(rb, 1'($urandom), rc, 18'($urandom), {$urandom, $urandom},
                20 + int'($urandom % 81), (i % 7) == 3);
    end
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule